// File: doc/BRIEF.md
# Aliased Multi-Width SIMD Register File

This block is the vector register storage for a SIMD datapath whose lanes change width from one operation to the next. A single bank of flip-flops is seen through three views. The narrow view has L registers of K lanes, each lane N bits wide. The medium view has L/2 registers with 2N-bit lanes. The wide view has L/4 registers with 4N-bit lanes. No view owns storage of its own, so the total is always L × K × N/8 bytes. A medium or wide register is made of consecutive narrow registers. They are joined lane by lane, so lane j of a wider register holds lane j of each narrow register that forms it. The higher-numbered narrow register sits in the more significant part.

There are two combinational read ports and one write port. Each port carries a 2-bit view selector (00 narrow, 01 medium, 10 wide, 11 illegal), a register index, and a data bus of K slots that are 4N bits each. Slot j sits at bits [j·4N +: 4N]. A narrow value sits in the low N bits of its slot and a medium value sits in the low 2N bits. Unused upper bits read as zero and are ignored on writes. The write port also has one enable bit per lane. Parameters N, L and K default to 8, 32 and 8. Elaboration rejects any L that is not a multiple of 4.

Top module: `alias_vrf`

## Requirements
- R1: A synchronous active-high reset clears all storage, so every register in every view reads zero afterwards.
- R2: A narrow write of register r commits at the rising edge. From then on, slot j of a narrow read of r returns write slot j bits [N-1:0], with bits above N read as zero.
- R3: Medium register i, slot j, reads as {narrow 2i+1 lane j, narrow 2i lane j} in bits [2N-1:0], with upper bits zero.
- R4: Wide register i, slot j, reads as {narrow 4i+3, 4i+2, 4i+1, 4i lane j}, from most to least significant, filling all 4N bits.
- R5: A write through the medium or wide view updates the underlying narrow registers, and the change shows in every view from the next cycle on.
- R6: When lane enable bit j is 0, every narrow byte under lane j of the addressed register keeps its value. Enabled lanes are written.
- R7: View selector 11 reads as all zero with the error flag low, and a write with selector 11 changes no storage.
- R8: An index at or above the register count of its view (L, L/2 or L/4) raises that port's error flag. The read returns zero and the write changes no storage.
- R9: A read of a location being written in the same cycle returns the old contents. There is no bypass.
- R10: The two read ports are independent. Each returns its own view and register in the same cycle.
- R11: With the write enable low, no storage changes, whatever the other write inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| rd0_cls | input | 2 | Read port 0 view selector |
| rd0_idx | input | IDXW | Read port 0 register index |
| rd0_data | output | K·4N | Read port 0 data, one 4N slot per lane |
| rd0_err | output | 1 | Read port 0 index out of range |
| rd1_cls | input | 2 | Read port 1 view selector |
| rd1_idx | input | IDXW | Read port 1 register index |
| rd1_data | output | K·4N | Read port 1 data |
| rd1_err | output | 1 | Read port 1 index out of range |
| wr_en | input | 1 | Write enable |
| wr_cls | input | 2 | Write view selector |
| wr_idx | input | IDXW | Write register index |
| wr_lane_we | input | K | Per-lane write enables |
| wr_data | input | K·4N | Write data, one 4N slot per lane |
| wr_err | output | 1 | Write index out of range |

## Verification
The hardest case to reach from the ports is a partial-lane write through a wide view that lands on narrow registers already holding different data, since a wrong mapping only shows when neighbouring bytes differ. The stimulus first fills whole groups of narrow registers with distinct byte patterns through the wide view. It then overwrites half the lanes through the medium view and reads the result back through all three views. An out-of-range medium index that would wrap onto registers 0 and 1 is written, and those registers are read back to show that the write was suppressed.

// File: rtl/avrf_pkg.sv
package avrf_pkg;

   typedef enum logic [1:0] {
      VIEW_NARROW = 2'b00,
      VIEW_MEDIUM = 2'b01,
      VIEW_WIDE   = 2'b10,
      VIEW_BAD    = 2'b11
   } view_e;

   // log2 of how many narrow registers make one register of the view
   function automatic logic [1:0] view_shift(input logic [1:0] v);
      case (v)
         VIEW_MEDIUM: view_shift = 2'd1;
         VIEW_WIDE:   view_shift = 2'd2;
         default:     view_shift = 2'd0;
      endcase
   endfunction

   function automatic logic view_legal(input logic [1:0] v);
      view_legal = (v != VIEW_BAD);
   endfunction

endpackage

// File: rtl/avrf_index_check.sv
module avrf_index_check #(
   parameter int unsigned NUM_BASE = 32,
   parameter int unsigned IDXW     = 5
) (
   input  logic [1:0]      cls,
   input  logic [IDXW-1:0] idx,
   output logic            ok,
   output logic            err
);
   import avrf_pkg::*;

   localparam logic [IDXW:0] LIM_NARROW = (IDXW+1)'(NUM_BASE);
   localparam logic [IDXW:0] LIM_MEDIUM = (IDXW+1)'(NUM_BASE / 2);
   localparam logic [IDXW:0] LIM_WIDE   = (IDXW+1)'(NUM_BASE / 4);

   logic [IDXW:0] limit;
   logic          legal;
   logic          in_range;

   always_comb begin
      case (cls)
         VIEW_MEDIUM: limit = LIM_MEDIUM;
         VIEW_WIDE:   limit = LIM_WIDE;
         default:     limit = LIM_NARROW;
      endcase
      legal    = view_legal(cls);
      in_range = ({1'b0, idx} < limit);
      ok       = legal & in_range;
      err      = legal & ~in_range;
   end

endmodule

// File: rtl/avrf_read_port.sv
module avrf_read_port #(
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned NUM_BASE = 32,
   parameter int unsigned LANES    = 8,
   parameter int unsigned IDXW     = 5
) (
   input  logic [NUM_BASE-1:0][LANES-1:0][LANE_W-1:0] mem,
   input  logic [1:0]                                 cls,
   input  logic [IDXW-1:0]                            idx,
   input  logic                                       ok,
   output logic [LANES*4*LANE_W-1:0]                  data
);
   import avrf_pkg::*;

   localparam int unsigned SLOT_W = 4 * LANE_W;

   logic [1:0]      sh;
   logic [2:0]      span;
   logic [IDXW+1:0] base;
   logic [IDXW-1:0] row_q  [4];
   logic [3:0]      q_used;

   always_comb begin
      sh   = view_shift(cls);
      span = 3'd1 << sh;
      base = {2'b00, idx} << sh;
      for (int q = 0; q < 4; q++) begin
         row_q[q]  = IDXW'(base + (IDXW+2)'(q));
         q_used[q] = (3'(q) < span);
      end
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      for (genvar q = 0; q < 4; q++) begin : g_part
         logic [LANE_W-1:0] part;
         always_comb begin
            part = '0;
            if (ok && q_used[q]) part = mem[row_q[q]][j];
         end
         assign data[j*SLOT_W + q*LANE_W +: LANE_W] = part;
      end
   end

endmodule

// File: rtl/avrf_write_spread.sv
module avrf_write_spread #(
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned NUM_BASE = 32,
   parameter int unsigned LANES    = 8,
   parameter int unsigned IDXW     = 5
) (
   input  logic                                       wr_en,
   input  logic [1:0]                                 cls,
   input  logic [IDXW-1:0]                            idx,
   input  logic                                       ok,
   input  logic [LANES-1:0]                           lane_we,
   input  logic [LANES*4*LANE_W-1:0]                  wdata,
   output logic [NUM_BASE-1:0][LANES-1:0]             row_we,
   output logic [NUM_BASE-1:0][LANES-1:0][LANE_W-1:0] row_data
);
   import avrf_pkg::*;

   localparam int unsigned SLOT_W = 4 * LANE_W;

   logic [1:0] sh;
   logic       go;

   always_comb begin
      sh = view_shift(cls);
      go = wr_en & ok;
   end

   for (genvar r = 0; r < NUM_BASE; r++) begin : g_row
      localparam logic [IDXW+1:0] ROW = (IDXW+2)'(r);
      logic [IDXW+1:0] grp;
      logic [1:0]      part;
      logic            hit;
      always_comb begin
         grp  = ROW >> sh;
         part = 2'(ROW & ((IDXW+2)'(1) << sh) - (IDXW+2)'(1));
         hit  = go & (grp == {2'b00, idx});
         for (int j = 0; j < LANES; j++) begin
            row_we[r][j]   = hit & lane_we[j];
            row_data[r][j] = wdata[j*SLOT_W + int'(part)*LANE_W +: LANE_W];
         end
      end
   end

endmodule

// File: rtl/alias_vrf.sv
module alias_vrf #(
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned NUM_BASE = 32,
   parameter int unsigned LANES    = 8,
   localparam int unsigned IDXW    = $clog2(NUM_BASE),
   localparam int unsigned DW      = LANES * 4 * LANE_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       rd0_cls,
   input  logic [IDXW-1:0]  rd0_idx,
   output logic [DW-1:0]    rd0_data,
   output logic             rd0_err,
   input  logic [1:0]       rd1_cls,
   input  logic [IDXW-1:0]  rd1_idx,
   output logic [DW-1:0]    rd1_data,
   output logic             rd1_err,
   input  logic             wr_en,
   input  logic [1:0]       wr_cls,
   input  logic [IDXW-1:0]  wr_idx,
   input  logic [LANES-1:0] wr_lane_we,
   input  logic [DW-1:0]    wr_data,
   output logic             wr_err
);

   localparam int unsigned NRD = 2;

   if (NUM_BASE < 4 || (NUM_BASE % 4) != 0) begin : g_bad_base
      $error("alias_vrf: NUM_BASE must be a non-zero multiple of 4");
   end
   if (LANE_W < 1 || LANES < 1) begin : g_bad_lane
      $error("alias_vrf: LANE_W and LANES must be at least 1");
   end

   logic [NUM_BASE-1:0][LANES-1:0][LANE_W-1:0] mem;
   logic [NUM_BASE-1:0][LANES-1:0]             row_we;
   logic [NUM_BASE-1:0][LANES-1:0][LANE_W-1:0] row_data;

   logic [1:0]      rcls [NRD];
   logic [IDXW-1:0] ridx [NRD];
   logic [DW-1:0]   rdat [NRD];
   logic            rok  [NRD];
   logic            rerr [NRD];
   logic            wok;

   assign rcls[0] = rd0_cls;
   assign ridx[0] = rd0_idx;
   assign rcls[1] = rd1_cls;
   assign ridx[1] = rd1_idx;

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      avrf_index_check #(.NUM_BASE(NUM_BASE), .IDXW(IDXW)) u_chk (
         .cls (rcls[p]),
         .idx (ridx[p]),
         .ok  (rok[p]),
         .err (rerr[p])
      );
      avrf_read_port #(
         .LANE_W(LANE_W), .NUM_BASE(NUM_BASE), .LANES(LANES), .IDXW(IDXW)
      ) u_port (
         .mem  (mem),
         .cls  (rcls[p]),
         .idx  (ridx[p]),
         .ok   (rok[p]),
         .data (rdat[p])
      );
   end

   assign rd0_data = rdat[0];
   assign rd0_err  = rerr[0];
   assign rd1_data = rdat[1];
   assign rd1_err  = rerr[1];

   avrf_index_check #(.NUM_BASE(NUM_BASE), .IDXW(IDXW)) u_wchk (
      .cls (wr_cls),
      .idx (wr_idx),
      .ok  (wok),
      .err (wr_err)
   );

   avrf_write_spread #(
      .LANE_W(LANE_W), .NUM_BASE(NUM_BASE), .LANES(LANES), .IDXW(IDXW)
   ) u_spread (
      .wr_en    (wr_en),
      .cls      (wr_cls),
      .idx      (wr_idx),
      .ok       (wok),
      .lane_we  (wr_lane_we),
      .wdata    (wr_data),
      .row_we   (row_we),
      .row_data (row_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mem <= '0;
      end else begin
         for (int r = 0; r < NUM_BASE; r++) begin
            for (int j = 0; j < LANES; j++) begin
               if (row_we[r][j]) mem[r][j] <= row_data[r][j];
            end
         end
      end
   end

endmodule

// File: rtl/avrf_checker.sv
module avrf_checker #(
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned NUM_BASE = 32,
   parameter int unsigned LANES    = 8,
   parameter int unsigned IDXW     = 5,
   parameter int unsigned DW       = LANES * 4 * LANE_W
) (
   input logic                             clk,
   input logic                             rst,
   input logic [1:0]                       rd0_cls,
   input logic [IDXW-1:0]                  rd0_idx,
   input logic [DW-1:0]                    rd0_data,
   input logic                             rd0_err,
   input logic [1:0]                       rd1_cls,
   input logic [IDXW-1:0]                  rd1_idx,
   input logic [DW-1:0]                    rd1_data,
   input logic                             rd1_err,
   input logic                             wr_en,
   input logic [1:0]                       wr_cls,
   input logic [IDXW-1:0]                  wr_idx,
   input logic [LANES-1:0]                 wr_lane_we,
   input logic [DW-1:0]                    wr_data,
   input logic                             wr_err,
   input logic [NUM_BASE*LANES*LANE_W-1:0] mem_flat
);

   localparam int unsigned SLOT_W = 4 * LANE_W;

   function automatic logic [DW-1:0] narrow_view(input logic [DW-1:0] d);
      narrow_view = '0;
      for (int j = 0; j < LANES; j++)
         narrow_view[j*SLOT_W +: LANE_W] = d[j*SLOT_W +: LANE_W];
   endfunction

   function automatic logic [LANES*LANE_W-1:0] low_parts(input logic [DW-1:0] d);
      for (int j = 0; j < LANES; j++)
         low_parts[j*LANE_W +: LANE_W] = d[j*SLOT_W +: LANE_W];
   endfunction

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (mem_flat == '0)); // R1

   AST_NARROW_ROUND_TRIP: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_cls == 2'b00 && !wr_err && (&wr_lane_we))
      ##1 (rd0_cls == 2'b00 && rd0_idx == $past(wr_idx))
      |-> (rd0_data == narrow_view($past(wr_data)))); // R2

   AST_MEDIUM_LOW_ALIAS: assert property (@(posedge clk) disable iff (rst)
      (rd0_cls == 2'b01 && !rd0_err && rd1_cls == 2'b00 &&
       rd1_idx == IDXW'({rd0_idx, 1'b0}))
      |-> (low_parts(rd0_data) == low_parts(rd1_data))); // R3

   AST_BAD_VIEW_ZERO: assert property (@(posedge clk) disable iff (rst)
      (rd0_cls == 2'b11) |-> (rd0_data == '0 && !rd0_err)); // R7

   AST_ERR0_ZERO: assert property (@(posedge clk) disable iff (rst)
      rd0_err |-> (rd0_data == '0)); // R8

   AST_ERR1_ZERO: assert property (@(posedge clk) disable iff (rst)
      rd1_err |-> (rd1_data == '0)); // R8

   AST_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
      (!wr_en || wr_err || wr_cls == 2'b11) |=> $stable(mem_flat)); // R11

endmodule

bind alias_vrf avrf_checker #(
   .LANE_W(LANE_W), .NUM_BASE(NUM_BASE), .LANES(LANES), .IDXW(IDXW), .DW(DW)
) u_avrf_checker (
   .clk(clk), .rst(rst),
   .rd0_cls(rd0_cls), .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_err(rd0_err),
   .rd1_cls(rd1_cls), .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_err(rd1_err),
   .wr_en(wr_en), .wr_cls(wr_cls), .wr_idx(wr_idx), .wr_lane_we(wr_lane_we),
   .wr_data(wr_data), .wr_err(wr_err), .mem_flat(mem)
);

// File: tb/alias_vrf_tb.sv
`timescale 1ns/1ps
module alias_vrf_tb;

   localparam int N  = 8;
   localparam int L  = 32;
   localparam int K  = 8;
   localparam int IW = 5;
   localparam int DW = K * 4 * N;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    rd0_cls = '0, rd1_cls = '0, wr_cls = '0;
   logic [IW-1:0] rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
   logic [DW-1:0] rd0_data, rd1_data, wr_data = '0;
   logic          rd0_err, rd1_err, wr_err;
   logic          wr_en = 1'b0;
   logic [K-1:0]  wr_lane_we = '0;

   always #2.5 clk = ~clk;

   alias_vrf #(.LANE_W(N), .NUM_BASE(L), .LANES(K)) u_dut (
      .clk(clk), .rst(rst),
      .rd0_cls(rd0_cls), .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_err(rd0_err),
      .rd1_cls(rd1_cls), .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_err(rd1_err),
      .wr_en(wr_en), .wr_cls(wr_cls), .wr_idx(wr_idx), .wr_lane_we(wr_lane_we),
      .wr_data(wr_data), .wr_err(wr_err)
   );

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [N-1:0] mdl [L][K];

   typedef struct packed {
      logic          we;
      logic [1:0]    wcls;
      logic [IW-1:0] widx;
      logic [K-1:0]  wmask;
      logic [7:0]    seed;
      logic [1:0]    r0cls;
      logic [IW-1:0] r0idx;
      logic          r0err;
      logic [1:0]    r1cls;
      logic [IW-1:0] r1idx;
      logic          r1err;
      logic [23:0]   tag;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 2'd0, 5'd0,  8'hFF, 8'd1,  2'd0, 5'd0,  1'b0, 2'd0, 5'd1,  1'b0, "R9 "},
      '{1'b1, 2'd0, 5'd1,  8'hFF, 8'd2,  2'd0, 5'd0,  1'b0, 2'd1, 5'd0,  1'b0, "R2 "},
      '{1'b0, 2'd0, 5'd0,  8'h00, 8'd0,  2'd1, 5'd0,  1'b0, 2'd0, 5'd1,  1'b0, "R3 "},
      '{1'b1, 2'd2, 5'd1,  8'hFF, 8'd3,  2'd0, 5'd5,  1'b0, 2'd2, 5'd0,  1'b0, "R9 "},
      '{1'b0, 2'd0, 5'd0,  8'h00, 8'd0,  2'd2, 5'd1,  1'b0, 2'd0, 5'd5,  1'b0, "R4 "},
      '{1'b0, 2'd0, 5'd0,  8'h00, 8'd0,  2'd0, 5'd7,  1'b0, 2'd1, 5'd2,  1'b0, "R5 "},
      '{1'b1, 2'd1, 5'd3,  8'h0F, 8'd4,  2'd2, 5'd1,  1'b0, 2'd1, 5'd3,  1'b0, "R6 "},
      '{1'b0, 2'd0, 5'd0,  8'h00, 8'd0,  2'd2, 5'd1,  1'b0, 2'd0, 5'd6,  1'b0, "R6 "},
      '{1'b1, 2'd3, 5'd0,  8'hFF, 8'd5,  2'd3, 5'd0,  1'b0, 2'd3, 5'd4,  1'b0, "R7 "},
      '{1'b0, 2'd0, 5'd0,  8'h00, 8'd0,  2'd0, 5'd0,  1'b0, 2'd1, 5'd0,  1'b0, "R7 "},
      '{1'b1, 2'd1, 5'd16, 8'hFF, 8'd6,  2'd1, 5'd16, 1'b1, 2'd2, 5'd8,  1'b1, "R8 "},
      '{1'b1, 2'd2, 5'd9,  8'hFF, 8'd7,  2'd2, 5'd9,  1'b1, 2'd1, 5'd0,  1'b0, "R8 "},
      '{1'b1, 2'd0, 5'd31, 8'hAA, 8'd8,  2'd0, 5'd31, 1'b0, 2'd3, 5'd31, 1'b0, "R6 "},
      '{1'b0, 2'd0, 5'd0,  8'h00, 8'd0,  2'd0, 5'd31, 1'b0, 2'd1, 5'd15, 1'b0, "R6 "},
      '{1'b0, 2'd0, 5'd0,  8'hFF, 8'd9,  2'd0, 5'd0,  1'b0, 2'd2, 5'd0,  1'b0, "R11"},
      '{1'b0, 2'd0, 5'd0,  8'h00, 8'd0,  2'd0, 5'd0,  1'b0, 2'd0, 5'd1,  1'b0, "R11"},
      '{1'b1, 2'd2, 5'd7,  8'hFF, 8'd10, 2'd2, 5'd7,  1'b0, 2'd0, 5'd28, 1'b0, "R10"},
      '{1'b0, 2'd0, 5'd0,  8'h00, 8'd0,  2'd0, 5'd28, 1'b0, 2'd0, 5'd31, 1'b0, "R10"},
      '{1'b0, 2'd0, 5'd0,  8'h00, 8'd0,  2'd2, 5'd7,  1'b0, 2'd1, 5'd14, 1'b0, "R5 "}
   };

   function automatic logic [DW-1:0] pat(input logic [7:0] seed);
      for (int b = 0; b < DW / 8; b++)
         pat[b*8 +: 8] = seed * 8'd29 + 8'(b) * 8'd7 + 8'd1;
   endfunction

   function automatic int span_of(input logic [1:0] c);
      return (c == 2'd2) ? 4 : (c == 2'd1) ? 2 : 1;
   endfunction

   function automatic bit in_range(input logic [1:0] c, input logic [IW-1:0] i);
      return (c != 2'd3) && (int'(i) < L / span_of(c));
   endfunction

   function automatic logic [DW-1:0] model_read(input logic [1:0] c, input logic [IW-1:0] i);
      model_read = '0;
      if (in_range(c, i))
         for (int j = 0; j < K; j++)
            for (int q = 0; q < span_of(c); q++)
               model_read[j*4*N + q*N +: N] = mdl[int'(i) * span_of(c) + q][j];
   endfunction

   task automatic model_write(input logic [1:0] c, input logic [IW-1:0] i,
                              input logic [K-1:0] m, input logic [DW-1:0] d);
      if (in_range(c, i))
         for (int j = 0; j < K; j++)
            if (m[j])
               for (int q = 0; q < span_of(c); q++)
                  mdl[int'(i) * span_of(c) + q][j] = d[j*4*N + q*N +: N];
   endtask

   task automatic model_clear();
      for (int r = 0; r < L; r++)
         for (int j = 0; j < K; j++) mdl[r][j] = '0;
   endtask

   task automatic chk(input logic [23:0] tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all): actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: every narrow register is zero after reset
      for (int r = 0; r < L; r++) begin
         @(negedge clk);
         rd0_cls = 2'd0;
         rd0_idx = IW'(r);
         #1;
         chk("R1 ", "narrow after reset", rd0_data, '0);
      end

      // vector table walk: reads are sampled before the edge that commits the write
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         wr_en      = VEC[v].we;
         wr_cls     = VEC[v].wcls;
         wr_idx     = VEC[v].widx;
         wr_lane_we = VEC[v].wmask;
         wr_data    = pat(VEC[v].seed);
         rd0_cls    = VEC[v].r0cls;
         rd0_idx    = VEC[v].r0idx;
         rd1_cls    = VEC[v].r1cls;
         rd1_idx    = VEC[v].r1idx;
         #1;
         chk(VEC[v].tag, "port0 data", rd0_data, model_read(VEC[v].r0cls, VEC[v].r0idx));
         chk(VEC[v].tag, "port0 err", DW'(rd0_err), DW'(VEC[v].r0err));
         chk(VEC[v].tag, "port1 data", rd1_data, model_read(VEC[v].r1cls, VEC[v].r1idx));
         chk(VEC[v].tag, "port1 err", DW'(rd1_err), DW'(VEC[v].r1err));
         chk(VEC[v].tag, "write err", DW'(wr_err),
             DW'(VEC[v].wcls != 2'd3 && !in_range(VEC[v].wcls, VEC[v].widx)));
         @(posedge clk);
         if (VEC[v].we) model_write(VEC[v].wcls, VEC[v].widx, VEC[v].wmask, pat(VEC[v].seed));
      end

      @(negedge clk);
      wr_en = 1'b0;

      // R3: medium 3 after the masked write: low lanes new, high lanes from wide write
      rd0_cls = 2'd1; rd0_idx = 5'd3;
      rd1_cls = 2'd0; rd1_idx = 5'd7;
      #1;
      chk("R3 ", "medium 3 after mask", rd0_data, model_read(2'd1, 5'd3));
      chk("R4 ", "narrow 7 after mask", rd1_data, model_read(2'd0, 5'd7));

      // R1: reset mid-run clears data that was written
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      model_clear();
      for (int w = 0; w < L / 4; w++) begin
         @(negedge clk);
         rd0_cls = 2'd2;
         rd0_idx = IW'(w);
         rd1_cls = 2'd1;
         rd1_idx = IW'(2 * w);
         #1;
         chk("R1 ", "wide after reset", rd0_data, '0);
         chk("R1 ", "medium after reset", rd1_data, '0);
      end

      finish_run();
   end

endmodule